// File: doc/BRIEF.md
# 1-Wire Bus Monitor Decoder

This block listens to one open-drain 1-Wire data line and never drives it. The line is sampled on the system clock. The block times each low pulse in clock ticks against a unit time that is set by a parameter (nominally 30 µs at normal speed), and from that timing it decides what each slot was:

- a data bit, whose value is the line level one unit after the falling edge;
- a bus reset, which is a low pulse longer than eight units;
- the presence answer, which is the line level two and a half units after the reset ends.

After every bus reset the block collects the next eight data bits into a command byte, least significant bit first. It then classifies the byte as one of the ROM-level commands. Every finding leaves the block as a one-clock strobe with its value. A bus analyser or a debug fabric can use these strobes to follow bus traffic without adding any load to the line.

Top module: `owire_listener`

## Requirements
- R1: `bitValid` pulses for one clock exactly TICKS_PER_UNIT+3 clocks after `lineIn` first reads low at a clock edge. `bitValue` is 1 if `lineIn` was high at the edge TICKS_PER_UNIT clocks after that fall, and 0 otherwise.
- R2: A low pulse that lasts at most 8·TICKS_PER_UNIT clocks, including exactly that length, yields only its 0 bit event and no reset.
- R3: A low pulse longer than 8·TICKS_PER_UNIT clocks yields its 0 bit event. It then yields a one-clock `resetValid` 3 clocks after `lineIn` returns high.
- R4: After a reset, `presValid` pulses 2.5·TICKS_PER_UNIT+3 clocks after `lineIn` returned high. `presDetected` is 1 when the line was low at 2.5·TICKS_PER_UNIT clocks after that rise. Edges inside that window start no slot.
- R5: After a reset, the next eight bits form `cmdByte`, with the first bit in bit 0. `cmdValid` pulses in the same clock as the eighth `bitValid`.
- R6: `cmdType` encoding:
  - 1 = 0x33 or 0x0F (read ROM)
  - 2 = 0xCC (skip ROM)
  - 3 = 0x55 (match ROM)
  - 4 = 0xF0 (search ROM)
  - 5 = 0x3C (fast-speed skip ROM)
  - 6 = 0x69 (fast-speed match ROM)
- R7: Any other command byte is reported with `cmdType` 0.
- R8: Bits that arrive before the first reset, or after a command byte and before the next reset, give bit events only and never a command event.
- R9: A reset in the middle of a byte discards the partial bits, so the next eight bits form a clean byte.
- R10: While `rstN` is low, all outputs are 0. After release, no byte is collected until a bus reset has been seen.
- R11: In every clock without an event, all outputs are 0, including `cmdByte` and `cmdType`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Raw level of the 1-Wire data line |
| bitValid | output | 1 | One-clock strobe: a data bit was sampled |
| bitValue | output | 1 | Sampled bit value, valid with `bitValid` |
| resetValid | output | 1 | One-clock strobe: a bus reset ended |
| presValid | output | 1 | One-clock strobe: the presence window was sampled |
| presDetected | output | 1 | 1 when a device answered, valid with `presValid` |
| cmdValid | output | 1 | One-clock strobe: a command byte completed |
| cmdByte | output | 8 | Assembled command byte, valid with `cmdValid` |
| cmdType | output | 3 | Command class code, valid with `cmdValid` |

## Verification
Two things happen in the same clock: the eighth data bit after a reset is reported as a plain bit event, and that same bit completes the command byte. The bench sends full bytes after bus resets, one byte for every command code and one unknown byte. It then expects `bitValid` and `cmdValid` together on one clock, with the final bit's value and the whole byte. The reference model judges this by packing all outputs into one word and comparing it with the expected word on every clock. A command strobe that is one clock early or late, or that is paired with the wrong bit, therefore shows up as a mismatch.

// File: rtl/owire_pkg.sv
package owire_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [1:0] {
    LS_IDLE,
    LS_SAMPLE,
    LS_WAIT_RISE,
    LS_PRESENCE
  } listenState_e;

  typedef enum logic [2:0] {
    CK_UNKNOWN    = 3'd0,
    CK_READ_ROM   = 3'd1,
    CK_SKIP_ROM   = 3'd2,
    CK_MATCH_ROM  = 3'd3,
    CK_SEARCH_ROM = 3'd4,
    CK_FAST_SKIP  = 3'd5,
    CK_FAST_MATCH = 3'd6
  } cmdKind_e;

  typedef struct packed {
    logic bitStb;
    logic bitVal;
    logic rstStb;
    logic presStb;
    logic presVal;
  } slotStrobes_t;

  function automatic cmdKind_e classifyCmd(input logic [CMD_W-1:0] code);
    case (code)
      8'h33, 8'h0F: classifyCmd = CK_READ_ROM;
      8'hCC:        classifyCmd = CK_SKIP_ROM;
      8'h55:        classifyCmd = CK_MATCH_ROM;
      8'hF0:        classifyCmd = CK_SEARCH_ROM;
      8'h3C:        classifyCmd = CK_FAST_SKIP;
      8'h69:        classifyCmd = CK_FAST_MATCH;
      default:      classifyCmd = CK_UNKNOWN;
    endcase
  endfunction

endpackage

// File: rtl/owire_line_sync.sv
module owire_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineS,
  output logic fallSeen,
  output logic riseSeen
);

  logic [SYNC_STAGES-1:0] chain;
  logic lineD;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= lineIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[SYNC_STAGES-2:0], lineIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineD <= 1'b1;
    else       lineD <= chain[SYNC_STAGES-1];
  end

  assign lineS    = chain[SYNC_STAGES-1];
  assign fallSeen = lineD & ~lineS;
  assign riseSeen = ~lineD & lineS;

endmodule

// File: rtl/owire_slot_ctrl.sv
module owire_slot_ctrl
  import owire_pkg::*;
#(
  parameter int TICKS_PER_UNIT      = 1500,
  parameter int RESET_UNITS         = 8,
  parameter int PRESENCE_HALF_UNITS = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         lineS,
  input  logic         fallSeen,
  input  logic         riseSeen,
  output slotStrobes_t strobes
);

  localparam int CNT_MAX = TICKS_PER_UNIT * RESET_UNITS + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] UNIT_C = CW'(TICKS_PER_UNIT);
  localparam logic [CW-1:0] RST_C  = CW'(TICKS_PER_UNIT * RESET_UNITS);
  localparam logic [CW-1:0] PRES_C = CW'((TICKS_PER_UNIT * PRESENCE_HALF_UNITS) / 2);
  localparam logic [CW-1:0] MAX_C  = CW'(CNT_MAX);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  listenState_e state, stateNext;
  logic [CW-1:0] cnt, cntNext, cntInc;

  assign cntInc = (cnt == MAX_C) ? cnt : cnt + ONE_C;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobes   = '0;
    case (state)
      LS_IDLE: begin
        if (fallSeen) begin
          stateNext = LS_SAMPLE;
          cntNext   = ONE_C;
        end
      end
      LS_SAMPLE: begin
        cntNext = cntInc;
        if (cnt == UNIT_C) begin
          strobes.bitStb = 1'b1;
          strobes.bitVal = lineS;
          stateNext      = lineS ? LS_IDLE : LS_WAIT_RISE;
        end
      end
      LS_WAIT_RISE: begin
        cntNext = cntInc;
        if (riseSeen) begin
          if (cnt > RST_C) begin
            strobes.rstStb = 1'b1;
            stateNext      = LS_PRESENCE;
            cntNext        = ONE_C;
          end else begin
            stateNext = LS_IDLE;
          end
        end
      end
      default: begin
        cntNext = cntInc;
        if (cnt == PRES_C) begin
          strobes.presStb = 1'b1;
          strobes.presVal = ~lineS;
          stateNext       = LS_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= LS_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  // R11: at most one kind of slot event per clock
  assert_one_event_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.bitStb, strobes.rstStb, strobes.presStb}));

  // R3: the pulse timer never runs past its saturation point
  assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= MAX_C);

endmodule

// File: rtl/owire_cmd_path.sv
module owire_cmd_path
  import owire_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  slotStrobes_t     strobes,
  output logic             bitValid,
  output logic             bitValue,
  output logic             resetValid,
  output logic             presValid,
  output logic             presDetected,
  output logic             cmdValid,
  output logic [CMD_W-1:0] cmdByte,
  output logic [2:0]       cmdType
);

  localparam int BCW = $clog2(CMD_W + 1);
  localparam logic [BCW-1:0] LAST_C = BCW'(CMD_W - 1);
  localparam logic [BCW-1:0] ONE_C  = BCW'(1);

  logic [CMD_W-1:0] shiftReg;
  logic [BCW-1:0]   bitCount;
  logic             collecting;
  logic [CMD_W-1:0] assembled;

  assign assembled = {strobes.bitVal, shiftReg[CMD_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitValid     <= 1'b0;
      bitValue     <= 1'b0;
      resetValid   <= 1'b0;
      presValid    <= 1'b0;
      presDetected <= 1'b0;
      cmdValid     <= 1'b0;
      cmdByte      <= '0;
      cmdType      <= CK_UNKNOWN;
      shiftReg     <= '0;
      bitCount     <= '0;
      collecting   <= 1'b0;
    end else begin
      bitValid     <= strobes.bitStb;
      bitValue     <= strobes.bitStb & strobes.bitVal;
      resetValid   <= strobes.rstStb;
      presValid    <= strobes.presStb;
      presDetected <= strobes.presStb & strobes.presVal;
      cmdValid     <= 1'b0;
      cmdByte      <= '0;
      cmdType      <= CK_UNKNOWN;
      if (strobes.rstStb) begin
        shiftReg   <= '0;
        bitCount   <= '0;
        collecting <= 1'b1;
      end else if (strobes.bitStb && collecting) begin
        shiftReg <= assembled;
        if (bitCount == LAST_C) begin
          cmdValid   <= 1'b1;
          cmdByte    <= assembled;
          cmdType    <= classifyCmd(assembled);
          collecting <= 1'b0;
          bitCount   <= '0;
        end else begin
          bitCount <= bitCount + ONE_C;
        end
      end
    end
  end

  // R5: a command always completes on a reported bit
  assert_cmd_with_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> bitValid);

  // R9: a bus reset leaves the assembler armed and empty
  assert_reset_arms_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.rstStb) |-> (collecting && bitCount == '0 && shiftReg == '0));

  // R11: bit strobes last a single clock
  assert_bit_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

endmodule

// File: rtl/owire_listener.sv
module owire_listener #(
  parameter int TICKS_PER_UNIT      = 1500,
  parameter int RESET_UNITS         = 8,
  parameter int PRESENCE_HALF_UNITS = 5,
  parameter int SYNC_STAGES         = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineIn,
  output logic       bitValid,
  output logic       bitValue,
  output logic       resetValid,
  output logic       presValid,
  output logic       presDetected,
  output logic       cmdValid,
  output logic [7:0] cmdByte,
  output logic [2:0] cmdType
);

  owire_pkg::slotStrobes_t strobes;
  logic lineS, fallSeen, riseSeen;

  owire_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .lineS(lineS), .fallSeen(fallSeen), .riseSeen(riseSeen)
  );

  owire_slot_ctrl #(
    .TICKS_PER_UNIT(TICKS_PER_UNIT),
    .RESET_UNITS(RESET_UNITS),
    .PRESENCE_HALF_UNITS(PRESENCE_HALF_UNITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lineS(lineS),
    .fallSeen(fallSeen), .riseSeen(riseSeen), .strobes(strobes)
  );

  owire_cmd_path u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .bitValid(bitValid), .bitValue(bitValue), .resetValid(resetValid),
    .presValid(presValid), .presDetected(presDetected),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .cmdType(cmdType)
  );

endmodule

// File: tb/owire_listener_bench.sv
module owire_listener_bench;

  localparam int T    = 20;
  localparam int RSTU = 8;
  localparam int PT   = 50;

  logic clk = 1'b0, rstN = 1'b0, lineIn = 1'b1;
  logic bitValid, bitValue, resetValid, presValid, presDetected, cmdValid;
  logic [7:0] cmdByte;
  logic [2:0] cmdType;

  owire_listener #(.TICKS_PER_UNIT(T)) u_owire_listener (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .bitValid(bitValid), .bitValue(bitValue), .resetValid(resetValid),
    .presValid(presValid), .presDetected(presDetected),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .cmdType(cmdType)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    logic [16:0] v;
    string       tag;
  } ev_t;

  ev_t q[$];
  int  nChecks = 0, nFails = 0;
  bit  monOn = 0, done = 0;

  // behavioural command assembler of the reference model
  int         mCount   = 0;
  bit         mCollect = 0;
  logic [7:0] mShift   = '0;

  function automatic logic [2:0] kindOf(input logic [7:0] b);
    if (b == 8'h33 || b == 8'h0F) return 3'd1;
    if (b == 8'hCC) return 3'd2;
    if (b == 8'h55) return 3'd3;
    if (b == 8'hF0) return 3'd4;
    if (b == 8'h3C) return 3'd5;
    if (b == 8'h69) return 3'd6;
    return 3'd0;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [16:0] act, input logic [16:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, expv);
    end
  endtask

  function automatic void pushEv(input int at, input logic [16:0] v, input string tag);
    ev_t e;
    e.at = at; e.v = v; e.tag = tag;
    q.push_back(e);
  endfunction

  // word layout: bitValid bitValue resetValid presValid presDetected cmdValid cmdByte cmdType
  function automatic void modelBit(input int at, input bit b, input string tag);
    logic [16:0] w;
    w = {1'b1, b, 4'b0000, 8'h00, 3'd0};
    if (mCollect) begin
      mShift = {b, mShift[7:1]};
      mCount++;
      if (mCount == 8) begin
        w[11] = 1'b1;
        w[10:3] = mShift;
        w[2:0] = kindOf(mShift);
        mCollect = 0;
        mCount = 0;
      end
    end
    pushEv(at, w, tag);
  endfunction

  always @(negedge clk) begin
    logic [16:0] act, expv;
    string tg;
    if (monOn) begin
      act = {bitValid, bitValue, resetValid, presValid, presDetected,
             cmdValid, cmdByte, cmdType};
      expv = '0;
      tg = "R11";
      if (q.size() > 0 && q[0].at < cyc) begin
        check(1'b0, q[0].tag, act, q[0].v);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].at == cyc) begin
        expv = q[0].v;
        tg = q[0].tag;
        void'(q.pop_front());
      end
      check(act == expv, tg, act, expv);
    end
  end

  // one low pulse; optional device answer after the rise
  task automatic slot(input int lowLen, input int presStart, input int presLen,
                      input int tail, input string tag);
    int t0;
    bit b;
    @(negedge clk);
    t0 = cyc;
    lineIn = 1'b0;
    b = (lowLen <= T);
    modelBit(t0 + T + 3, b, tag);
    if (!b && lowLen > RSTU * T) begin
      mShift = '0; mCount = 0; mCollect = 1;
      pushEv(t0 + lowLen + 3, {2'b00, 1'b1, 14'h0}, "R3");
      pushEv(t0 + lowLen + PT + 3,
             {3'b000, 1'b1, (presLen > 0 && presStart <= PT && presStart + presLen > PT),
              12'h0}, "R4");
    end
    repeat (lowLen) @(negedge clk);
    lineIn = 1'b1;
    if (presLen > 0) begin
      repeat (presStart) @(negedge clk);
      lineIn = 1'b0;
      repeat (presLen) @(negedge clk);
      lineIn = 1'b1;
    end
    repeat (tail) @(negedge clk);
  endtask

  task automatic sendBit(input bit b, input string tag);
    if (b) slot(5, 0, 0, 74, tag);
    else   slot(60, 0, 0, 19, tag);
  endtask

  task automatic sendByte(input logic [7:0] v, input string tag);
    for (int i = 0; i < 8; i++) sendBit(v[i], tag);
  endtask

  task automatic busReset(input bit present);
    if (present) slot(200, 20, 80, 40, "R3");
    else         slot(200, 0, 0, 100, "R4");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({bitValid, resetValid, presValid, cmdValid, cmdByte, cmdType} == '0,
          "R10", 17'({bitValid, resetValid, presValid, cmdValid, cmdByte, cmdType}), '0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    monOn = 1;

    sendByte(8'hCC, "R8");              // R8: no reset yet, bit events only
    busReset(1'b1);                     // R3, R4 present
    sendByte(8'hCC, "R5");              // R5, R6 skip
    sendBit(1'b1, "R8");                // R8: after command byte
    sendBit(1'b0, "R8");
    busReset(1'b0);                     // R4: no device answers
    sendByte(8'h33, "R6");
    busReset(1'b1); sendByte(8'h0F, "R6");
    busReset(1'b1); sendByte(8'h55, "R6");
    busReset(1'b1); sendByte(8'hF0, "R6");
    busReset(1'b1); sendByte(8'h3C, "R6");
    busReset(1'b1); sendByte(8'h69, "R6");
    busReset(1'b1); sendByte(8'hA5, "R7");
    slot(160, 0, 0, 40, "R2");          // R2: exactly 8T is still a bit
    slot(161, 0, 0, 100, "R3");         // R3: one tick more is a reset
    sendByte(8'h96, "R1");              // R1: mixed bit values
    busReset(1'b1);
    sendBit(1'b1, "R9"); sendBit(1'b0, "R9"); sendBit(1'b1, "R9");
    busReset(1'b1);                     // R9: partial byte discarded
    sendByte(8'h55, "R9");
    busReset(1'b1);
    sendBit(1'b1, "R10"); sendBit(1'b1, "R10");
    repeat (10) @(negedge clk);
    monOn = 0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check({bitValid, bitValue, resetValid, presValid, presDetected, cmdValid, cmdByte, cmdType} == '0,
          "R10", {bitValid, bitValue, resetValid, presValid, presDetected, cmdValid, cmdByte, cmdType}, '0);
    rstN = 1'b1;
    mCollect = 0; mCount = 0; mShift = '0;
    repeat (3) @(negedge clk);
    monOn = 1;
    sendByte(8'hF0, "R10");             // R10: not collecting after release
    busReset(1'b1);
    sendByte(8'hF0, "R6");
    repeat (20) @(negedge clk);
    if (q.size() != 0) check(1'b0, q[0].tag, '0, q[0].v);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule